// File: doc/BRIEF.md
# Keyed Flash Command Controller

This block is a register front-end for a small on-chip non-volatile array that is modelled behaviourally inside the module. Software uses a simple 32-bit register bus. It loads a byte address and a data word, then writes a command word whose upper half carries a fixed key. One command can program a word, erase a 1 KiB page, erase the whole array, or commit a pending write-protect setting. The accepted command bit reads back as 1 while the operation runs and drops to 0 when it finishes, so software can poll for completion.

The length of each operation is counted in microsecond ticks. A prescaler makes the tick, and its reload value is held in a register that software sets to the system clock in MHz minus one. The array is split into protection regions of two pages each. A program or erase aimed at a protected region does not change the array. Instead it raises an access-violation flag. That flag and a completion flag sit in a raw status register. A mask register and a masked-status view drive one interrupt line, and a write of 1 to the masked-status view clears a flag. A separate registered read port returns array words so the stored contents can be seen.

Top module: `nvm_keyed_ctrl`

## Requirements
- R1: After reset, the command bits, raw status, mask, masked status, microsecond reload and irq all read 0. The pending and active protection registers read all ones, which means every region is unprotected.
- R2: A write to the command register at offset 0x08 is acted on only when bits 31:16 equal 0xA442. Any other write there starts no operation and changes no status.
- R3: Command bit 0 programs one word. The word index is address bits [11:2]. The new word is the stored word ANDed with the data register at offset 0x04. The bit reads 1 while the operation runs, and on completion raw status bit 1 (done) is set.
- R4: Command bit 1 erases the page at address bits [11:10] (page size 1024 bytes). Every word of that page becomes 0xFFFFFFFF, and words in other pages keep their values.
- R5: Command bit 2 sets every word of the array to 0xFFFFFFFF, but only when no region is protected. Otherwise it is rejected as an access violation.
- R6: A program or page erase whose address lies in a protected region, or beyond the array, sets raw status bit 0 (violation) and leaves the array unchanged. The command bit already reads 0 in the next cycle.
- R7: Command bit 3 with the address register equal to 1 ANDs the pending protection register (offset 0x18, one bit per two-page region, 0 = protected) into the active one (read at offset 0x20). With any other address the command is an access violation. Active bits can never return to 1 except through reset.
- R8: A keyed write that sets more than one command bit, or that arrives while an operation runs, is ignored. No command bit and no status changes.
- R9: An operation lasts a fixed number of microsecond ticks, 2 for a program or commit and 8 for an erase. A tick occurs every reload+1 cycles (reload at offset 0x1C). A program therefore holds its command bit for 2*(reload+1) cycles and clears it on the next edge.
- R10: irq equals the OR of raw status AND mask (offset 0x10), and it follows one cycle after the raw status changes.
- R11: Offset 0x14 reads raw AND mask. Writing 1 to bit 0 or bit 1 there clears that raw flag, and a set on the same edge takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Interrupt, registered |
| rd_word | input | 10 | Array word index for the inspection read port |
| rd_data | output | 32 | Array word, one cycle after rd_word |

## Verification
Register read data appears on the cycle after the request edge. A read issued on the cycle right after a command write therefore already shows an accepted command bit, or a violation flag with a cleared command bit. A word program started at edge E clears its command bit at edge E + 2*(reload+1) + 1. With reload 3 the bench reads that bit at E+6, where it must still be set, and at E+12, where it must be clear. The interrupt line is sampled two cycles after a mask or clear write, because it lags the raw flags by one register. Erase results are read only after polling shows the command bit is clear.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  localparam logic [15:0] CMD_KEY = 16'hA442;

  localparam int OP_PROG   = 0;
  localparam int OP_PAGE   = 1;
  localparam int OP_MASS   = 2;
  localparam int OP_COMMIT = 3;

  localparam logic [5:0] OFS_ADDR = 6'h00;
  localparam logic [5:0] OFS_DATA = 6'h04;
  localparam logic [5:0] OFS_CMD  = 6'h08;
  localparam logic [5:0] OFS_RAW  = 6'h0C;
  localparam logic [5:0] OFS_MASK = 6'h10;
  localparam logic [5:0] OFS_MIS  = 6'h14;
  localparam logic [5:0] OFS_PROT = 6'h18;
  localparam logic [5:0] OFS_USEC = 6'h1C;
  localparam logic [5:0] OFS_PACT = 6'h20;

  typedef enum logic [1:0] {K_PROG, K_PAGE, K_MASS, K_COMMIT} op_e;
  typedef enum logic [2:0] {SQ_IDLE, SQ_RD, SQ_WR, SQ_WALK, SQ_WAIT} seq_state_e;
endpackage

// File: rtl/nvm_array.sv
module nvm_array #(
  parameter int WORDS = 1024,
  parameter int DW    = 32,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_rdata
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/nvm_usec_timer.sv
module nvm_usec_timer #(
  parameter int RW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [RW-1:0] reload,
  input  logic [CW-1:0] ticks,
  output logic          expired
);
  logic [RW-1:0] pre;
  logic [CW-1:0] rem;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre <= '0;
      rem <= '0;
    end else if (start) begin
      pre <= reload;
      rem <= ticks;
    end else if (rem != '0) begin
      if (pre == '0) begin
        pre <= reload;
        rem <= rem - 1'b1;
      end else begin
        pre <= pre - 1'b1;
      end
    end
  end

  assign expired = (rem == '0);
endmodule

// File: rtl/nvm_seq.sv
module nvm_seq
  import nvm_pkg::*;
#(
  parameter int WORDS = 1024,
  parameter int AW    = 10,
  parameter int WPP_W = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  op_e           op,
  input  logic [AW-1:0] word_addr,
  input  logic [31:0]   wdata,
  input  logic          expired,
  input  logic [31:0]   a_rdata,
  output logic          a_we,
  output logic [AW-1:0] a_addr,
  output logic [31:0]   a_wdata,
  output logic          done
);
  seq_state_e    state;
  logic [AW-1:0] ptr;
  logic [AW-1:0] last;
  logic [31:0]   mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SQ_IDLE;
      ptr    <= '0;
      last   <= '0;
      mask_q <= '0;
    end else begin
      case (state)
        SQ_IDLE: if (start) begin
          case (op)
            K_PROG: begin
              ptr    <= word_addr;
              mask_q <= wdata;
              state  <= SQ_RD;
            end
            K_PAGE: begin
              ptr   <= {word_addr[AW-1:WPP_W], {WPP_W{1'b0}}};
              last  <= {word_addr[AW-1:WPP_W], {WPP_W{1'b1}}};
              state <= SQ_WALK;
            end
            K_MASS: begin
              ptr   <= '0;
              last  <= AW'(WORDS - 1);
              state <= SQ_WALK;
            end
            default: state <= SQ_WAIT;
          endcase
        end
        SQ_RD:   state <= SQ_WR;
        SQ_WR:   state <= SQ_WAIT;
        SQ_WALK: begin
          if (ptr == last) state <= SQ_WAIT;
          else ptr <= ptr + 1'b1;
        end
        SQ_WAIT: if (expired) state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign a_addr  = ptr;
  assign a_we    = (state == SQ_WR) || (state == SQ_WALK);
  assign a_wdata = (state == SQ_WR) ? (a_rdata & mask_q) : '1;
  assign done    = (state == SQ_WAIT) && expired;
endmodule

// File: rtl/nvm_keyed_ctrl.sv
module nvm_keyed_ctrl
  import nvm_pkg::*;
#(
  parameter int PAGES            = 4,
  parameter int PAGE_BYTES       = 1024,
  parameter int PAGES_PER_REGION = 2,
  parameter int ERASE_US         = 8,
  parameter int PROG_US          = 2,
  parameter int USEC_W           = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  input  logic [$clog2(PAGES*PAGE_BYTES/4)-1:0] rd_word,
  output logic [31:0] rd_data
);
  localparam int WORDS   = PAGES * PAGE_BYTES / 4;
  localparam int AW      = $clog2(WORDS);
  localparam int WPP_W   = $clog2(PAGE_BYTES / 4);
  localparam int BA_W    = AW + 2;
  localparam int REGIONS = PAGES / PAGES_PER_REGION;
  localparam int REG_W   = (REGIONS > 1) ? $clog2(REGIONS) : 1;
  localparam int RSH     = $clog2(PAGE_BYTES * PAGES_PER_REGION);
  localparam int TW      = 16;

  logic [31:0]        addr_q, data_q;
  logic [3:0]         cmd_run;
  logic [1:0]         raw, mask;
  logic [REGIONS-1:0] prot_pend, prot_act;
  logic [USEC_W-1:0]  usec_q;

  logic          wr, cmd_wr, accept, viol, launch, oob, reg_locked;
  logic [3:0]    cbits;
  op_e           op_sel;
  logic [TW-1:0] ticks;
  logic          expired, done;
  logic          a_we;
  logic [AW-1:0] a_addr;
  logic [31:0]   a_wdata, a_rdata;

  assign wr     = bus_req && bus_we;
  assign cbits  = bus_wdata[3:0];
  assign cmd_wr = wr && (bus_addr == OFS_CMD) && (bus_wdata[31:16] == CMD_KEY);
  assign accept = cmd_wr && $onehot(cbits) && (cmd_run == '0);

  assign oob        = (addr_q >> BA_W) != 32'd0;
  assign reg_locked = ~prot_act[addr_q[RSH +: REG_W]];

  always_comb begin
    if (cbits[OP_PROG] || cbits[OP_PAGE]) viol = oob || reg_locked;
    else if (cbits[OP_MASS])              viol = ~(&prot_act);
    else                                  viol = (addr_q != 32'd1);
    viol = viol && accept;
  end

  assign launch = accept && !viol;

  always_comb begin
    if (cbits[OP_PROG])      op_sel = K_PROG;
    else if (cbits[OP_PAGE]) op_sel = K_PAGE;
    else if (cbits[OP_MASS]) op_sel = K_MASS;
    else                     op_sel = K_COMMIT;
  end

  assign ticks = (cbits[OP_PAGE] || cbits[OP_MASS]) ? TW'(ERASE_US) : TW'(PROG_US);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q    <= '0;
      data_q    <= '0;
      cmd_run   <= '0;
      raw       <= '0;
      mask      <= '0;
      prot_pend <= '1;
      prot_act  <= '1;
      usec_q    <= '0;
      irq       <= 1'b0;
    end else begin
      if (wr && bus_addr == OFS_ADDR) addr_q    <= bus_wdata;
      if (wr && bus_addr == OFS_DATA) data_q    <= bus_wdata;
      if (wr && bus_addr == OFS_MASK) mask      <= bus_wdata[1:0];
      if (wr && bus_addr == OFS_PROT) prot_pend <= bus_wdata[REGIONS-1:0];
      if (wr && bus_addr == OFS_USEC) usec_q    <= bus_wdata[USEC_W-1:0];

      if (launch)    cmd_run <= cbits;
      else if (done) cmd_run <= '0;

      if (done && cmd_run[OP_COMMIT]) prot_act <= prot_act & prot_pend;

      raw <= (raw & ~((wr && bus_addr == OFS_MIS) ? bus_wdata[1:0] : 2'b00))
             | {done, viol};
      irq <= |(raw & mask);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_req && !bus_we) begin
      case (bus_addr)
        OFS_ADDR: bus_rdata <= addr_q;
        OFS_DATA: bus_rdata <= data_q;
        OFS_CMD:  bus_rdata <= {28'd0, cmd_run};
        OFS_RAW:  bus_rdata <= {30'd0, raw};
        OFS_MASK: bus_rdata <= {30'd0, mask};
        OFS_MIS:  bus_rdata <= {30'd0, raw & mask};
        OFS_PROT: bus_rdata <= 32'(prot_pend);
        OFS_USEC: bus_rdata <= 32'(usec_q);
        OFS_PACT: bus_rdata <= 32'(prot_act);
        default:  bus_rdata <= '0;
      endcase
    end
  end

  nvm_usec_timer #(.RW(USEC_W), .CW(TW)) u_timer (
    .clk(clk), .rst(rst), .start(launch), .reload(usec_q),
    .ticks(ticks), .expired(expired)
  );

  nvm_seq #(.WORDS(WORDS), .AW(AW), .WPP_W(WPP_W)) u_seq (
    .clk(clk), .rst(rst), .start(launch), .op(op_sel),
    .word_addr(addr_q[BA_W-1:2]), .wdata(data_q), .expired(expired),
    .a_rdata(a_rdata), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .done(done)
  );

  nvm_array #(.WORDS(WORDS), .DW(32), .AW(AW)) u_array (
    .clk(clk), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .b_addr(rd_word), .b_rdata(rd_data)
  );
endmodule

// File: rtl/nvm_keyed_ctrl_chk.sv
module nvm_keyed_ctrl_chk #(
  parameter int PW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic [3:0]    cmd_run,
  input logic [1:0]    raw,
  input logic [1:0]    mask,
  input logic          irq,
  input logic [PW-1:0] prot_act,
  input logic          arr_we
);
  // R1
  reset_clean_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cmd_run == 4'd0 && raw == 2'd0 && !irq));

  // R8
  cmd_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd_run));

  // R6
  write_needs_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> (cmd_run != 4'd0));

  // R3
  done_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(raw[1]) |-> $fell(|cmd_run));

  // R7
  prot_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
    (prot_act & ~$past(prot_act)) == '0);

  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(mask) == 2'd0) |-> !irq);
endmodule

bind nvm_keyed_ctrl nvm_keyed_ctrl_chk #(.PW(REGIONS)) u_chk (
  .clk(clk), .rst(rst), .cmd_run(cmd_run), .raw(raw), .mask(mask),
  .irq(irq), .prot_act(prot_act), .arr_we(a_we)
);

// File: tb/tb_nvm_keyed_ctrl.sv
module tb_nvm_keyed_ctrl;
  localparam logic [31:0] KEY = 32'hA442_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic [9:0]  rd_word = '0;
  logic [31:0] rd_data;

  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  nvm_keyed_ctrl dut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .rd_word(rd_word), .rd_data(rd_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // all bus tasks start and end just after a falling edge
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_req = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_req = 0;
  endtask

  task automatic frd(input int w, output logic [31:0] d);
    rd_word = 10'(w);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] v;
    for (int i = 0; i < 5000; i++) begin
      rd(6'h08, v);
      if (v[3:0] == 4'd0) return;
    end
    check({tag, " command never completed"}, v, 32'd0);
  endtask

  task automatic expect_reg(input string tag, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic expect_word(input string tag, input int w, input logic [31:0] exp);
    logic [31:0] v;
    frd(w, v);
    check(tag, v, exp);
  endtask

  task automatic t_reset;
    expect_reg("R1 cmd", 6'h08, 0);
    expect_reg("R1 raw", 6'h0C, 0);
    expect_reg("R1 mask", 6'h10, 0);
    expect_reg("R1 masked", 6'h14, 0);
    expect_reg("R1 usec", 6'h1C, 0);
    expect_reg("R1 prot pending", 6'h18, 32'h3);
    expect_reg("R1 prot active", 6'h20, 32'h3);
    check("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_mass;
    wr(6'h08, KEY | 32'h4);
    expect_reg("R5 mass busy bit", 6'h08, 32'h4);
    wait_idle("R5");
    expect_word("R5 word 0", 0, 32'hFFFF_FFFF);
    expect_word("R5 word 500", 500, 32'hFFFF_FFFF);
    expect_word("R5 word 1023", 1023, 32'hFFFF_FFFF);
    expect_reg("R3 done flag after erase", 6'h0C, 32'h2);
    wr(6'h14, 32'h3);
    expect_reg("R11 w1c clears raw", 6'h0C, 0);
  endtask

  task automatic t_key;
    wr(6'h00, 32'h18);
    wr(6'h04, 32'h0);
    wr(6'h08, 32'h1234_0001);
    expect_reg("R2 bad key cmd", 6'h08, 0);
    repeat (20) @(negedge clk);
    expect_reg("R2 bad key raw", 6'h0C, 0);
    expect_word("R2 bad key word", 6, 32'hFFFF_FFFF);
  endtask

  task automatic t_program;
    wr(6'h00, 32'h10);
    wr(6'h04, 32'hF0F0_00FF);
    wr(6'h08, KEY | 32'h1);
    expect_reg("R3 busy bit", 6'h08, 32'h1);
    wait_idle("R3");
    expect_word("R3 first program", 4, 32'hF0F0_00FF);
    wr(6'h04, 32'h0FFF_FF0F);
    wr(6'h08, KEY | 32'h1);
    wait_idle("R3");
    expect_word("R3 AND program", 4, 32'h00F0_000F);
    expect_reg("R3 done flag", 6'h0C, 32'h2);
    wr(6'h14, 32'h3);
  endtask

  task automatic t_timing;
    wr(6'h1C, 32'd3);
    wr(6'h00, 32'h14);
    wr(6'h04, 32'h1234_5678);
    wr(6'h08, KEY | 32'h1);
    repeat (5) @(negedge clk);
    expect_reg("R9 bit set at +6", 6'h08, 32'h1);
    repeat (5) @(negedge clk);
    expect_reg("R9 bit clear at +12", 6'h08, 32'h0);
    expect_word("R9 programmed word", 5, 32'h1234_5678);
  endtask

  task automatic t_page;
    wr(6'h00, 32'h400);
    wr(6'h04, 32'h0);
    wr(6'h08, KEY | 32'h1);
    wait_idle("R4");
    expect_word("R4 before erase", 256, 32'h0);
    wr(6'h08, KEY | 32'h2);
    wait_idle("R4");
    expect_word("R4 page first", 256, 32'hFFFF_FFFF);
    expect_word("R4 other page kept", 4, 32'h00F0_000F);
    wr(6'h14, 32'h3);
  endtask

  task automatic t_protect;
    wr(6'h18, 32'h2);
    expect_reg("R7 pending", 6'h18, 32'h2);
    expect_reg("R7 active before commit", 6'h20, 32'h3);
    wr(6'h00, 32'h0);
    wr(6'h08, KEY | 32'h8);
    expect_reg("R7 commit bad address", 6'h0C, 32'h1);
    wr(6'h14, 32'h1);
    wr(6'h00, 32'h1);
    wr(6'h08, KEY | 32'h8);
    wait_idle("R7");
    expect_reg("R7 active after commit", 6'h20, 32'h2);
    wr(6'h14, 32'h3);
    wr(6'h00, 32'h8);
    wr(6'h04, 32'h0);
    wr(6'h08, KEY | 32'h1);
    expect_reg("R6 cmd bit clear", 6'h08, 0);
    expect_reg("R6 violation flag", 6'h0C, 32'h1);
    expect_word("R6 word unchanged", 2, 32'hFFFF_FFFF);
    wr(6'h14, 32'h1);
    wr(6'h00, 32'h0);
    wr(6'h08, KEY | 32'h2);
    expect_reg("R6 page erase violation", 6'h0C, 32'h1);
    expect_word("R6 page kept", 4, 32'h00F0_000F);
    wr(6'h14, 32'h1);
    wr(6'h08, KEY | 32'h4);
    expect_reg("R5 mass rejected", 6'h0C, 32'h1);
    expect_word("R5 mass left array", 4, 32'h00F0_000F);
    wr(6'h14, 32'h1);
    wr(6'h00, 32'h800);
    wr(6'h04, 32'hA5A5_A5A5);
    wr(6'h08, KEY | 32'h1);
    wait_idle("R6");
    expect_word("R6 open region programs", 512, 32'hA5A5_A5A5);
    wr(6'h18, 32'h3);
    wr(6'h00, 32'h1);
    wr(6'h08, KEY | 32'h8);
    wait_idle("R7");
    expect_reg("R7 cannot unprotect", 6'h20, 32'h2);
    wr(6'h14, 32'h3);
  endtask

  task automatic t_ignore;
    wr(6'h08, KEY | 32'h3);
    expect_reg("R8 two bits cmd", 6'h08, 0);
    expect_reg("R8 two bits raw", 6'h0C, 0);
    wr(6'h00, 32'h800);
    wr(6'h08, KEY | 32'h2);
    wr(6'h00, 32'h8);
    wr(6'h08, KEY | 32'h1);
    expect_reg("R8 busy keeps erase bit", 6'h08, 32'h2);
    wait_idle("R8");
    expect_reg("R8 no violation from busy write", 6'h0C, 32'h2);
    expect_word("R8 erase done", 512, 32'hFFFF_FFFF);
  endtask

  task automatic t_irq;
    check("R10 irq masked off", {31'd0, irq}, 0);
    wr(6'h10, 32'h2);
    @(negedge clk);
    check("R10 irq raised", {31'd0, irq}, 1);
    expect_reg("R11 masked view", 6'h14, 32'h2);
    wr(6'h14, 32'h2);
    @(negedge clk);
    check("R11 irq after clear", {31'd0, irq}, 0);
    expect_reg("R11 raw after clear", 6'h0C, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_mass();
    t_key();
    t_program();
    t_timing();
    t_page();
    t_protect();
    t_ignore();
    t_irq();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule